// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Page Buffer

This block is the slave side of a two-wire serial bus (I2C) in front of a 128-byte memory. The system clock samples both bus lines; no bus line is used as a clock. The block finds start and stop conditions, checks the control byte against a fixed device code and acknowledges. It keeps a word pointer and carries out byte writes, page writes, current-address reads, random reads and sequential reads.

Written bytes first go to an eight-slot page buffer. The stop that ends a write launches an internal write cycle. A down-counter whose length is a parameter models that cycle, and when it expires the buffered bytes are copied into the register array. While the cycle runs, the slave ignores the bus. A separate level input gates every write.

The open-drain data line is modelled as a pull-down request. The bus level the block sees is the wired-AND of the master's drive and that request.

Top module: `i2c_page_eeprom`

## Requirements
- R1: After reset the data line is released, every memory byte reads 0x00 and the word pointer is 0x00.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Bits travel MSB first. A control byte is acknowledged only if its bits 7..1 equal 1010000. Its bit 0 selects a read (1) or a write (0). On any other control byte the slave stays silent and ignores the bus until the next start.
- R3: In a write, the byte after the control byte loads the word pointer. Each following byte is a data byte, and the slave acknowledges each one.
- R4: After each data byte only the pointer's three low bits increment. The four upper bits, which select the 8-byte page, do not change.
- R5: When more than eight data bytes arrive, the pointer wraps inside the page. Later bytes overwrite earlier buffered bytes in arrival order.
- R6: A stop that ends a write holding at least one data byte starts an internal cycle of WR_CYCLES clocks. At the end of that cycle the buffer is copied into the array. Until then no control byte is acknowledged, not even the slave's own.
- R7: A write is committed only if the write-enable input stayed high from the start to the stop. A blocked write starts no internal cycle. Lowering write-enable during the internal cycle does not cancel it.
- R8: A read returns the byte at the pointer, and the pointer then advances by one. A master acknowledge asks for the next byte. A master non-acknowledge ends the read, and the slave releases SDA.
- R9: A repeated start after the word address ends the write phase and keeps the loaded pointer, which allows a random read. A read-control byte alone reads from the current pointer.
- R10: During reads the whole 7-bit pointer increments and wraps from 0x7F to 0x00.
- R11: A stop that arrives after the word address but before any data byte starts no internal cycle.
- R12: The slave changes its drive on the data line only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Data line level as seen on the wired bus |
| wen_i | input | 1 | Write-enable level; high allows writes |
| sda_pull_o | output | 1 | High requests that the data line be pulled low |

## Verification
The bench builds the block with WR_CYCLES = 600 and keeps the other parameters at their defaults. At that length, several acknowledge polls fit inside one write cycle, so silence during the cycle can be seen on the bus, and a full cycle is still cheap to wait out. The default depth and page size keep the page-boundary crossing at 0x27/0x28 and the 0x7F-to-0x00 pointer wrap within a few hundred bus bits.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_CTRL = 3'd1,
        S_ADDR = 3'd2,
        S_WDAT = 3'd3,
        S_TX   = 3'd4
    } eep_st_e;
endpackage

// File: rtl/eep_bus_sense.sv
module eep_bus_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    // [0],[1] synchronise, [2] holds the previous settled sample
    logic [2:0] scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[1:0], scl_i};
            sda_q <= {sda_q[1:0], sda_i};
        end
    end

    assign scl_o   = scl_q[1];
    assign sda_o   = sda_q[1];
    assign start_o = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
    assign stop_o  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
    assign rise_o  = scl_q[1] & ~scl_q[2];
    assign fall_o  = ~scl_q[1] & scl_q[2];
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
    parameter int PAGE_BYTES = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr_i,
    input  logic                          wr_i,
    input  logic [$clog2(PAGE_BYTES)-1:0] idx_i,
    input  logic [7:0]                    byte_i,
    output logic [PAGE_BYTES*8-1:0]       data_o,
    output logic [PAGE_BYTES-1:0]         mask_o
);
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic [7:0] slot_q;
        logic       vld_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
                vld_q  <= 1'b0;
            end else begin
                if (wr_i && idx_i == g) slot_q <= byte_i;
                if (clr_i)                     vld_q <= 1'b0;
                else if (wr_i && idx_i == g)   vld_q <= 1'b1;
            end
        end
        assign data_o[g*8 +: 8] = slot_q;
        assign mask_o[g]        = vld_q;
    end

    // R5: a written slot is marked, whatever it held before
    a_r5_slot_marked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i) |=> mask_o[$past(idx_i)]);
    // R6: a clear empties the whole buffer
    a_r6_buffer_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (mask_o == '0));
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int MEM_DEPTH  = 128,
    parameter int PAGE_BYTES = 8
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    input  logic                                            wr_i,
    input  logic [$clog2(MEM_DEPTH)-$clog2(PAGE_BYTES)-1:0] page_i,
    input  logic [PAGE_BYTES*8-1:0]                         data_i,
    input  logic [PAGE_BYTES-1:0]                           mask_i,
    input  logic [$clog2(MEM_DEPTH)-1:0]                    raddr_i,
    output logic [7:0]                                      rdata_o
);
    localparam int OW = $clog2(PAGE_BYTES);

    logic [7:0] mem_q [MEM_DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_i) begin
            for (int j = 0; j < PAGE_BYTES; j++)
                if (mask_i[j]) mem_q[{page_i, OW'(j)}] <= data_i[j*8 +: 8];
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_page_eeprom.sv
module i2c_page_eeprom #(
    parameter int         MEM_DEPTH  = 128,
    parameter int         PAGE_BYTES = 8,
    parameter int         WR_CYCLES  = 5000,
    parameter logic [6:0] DEV_ID     = 7'b1010000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wen_i,
    output logic sda_pull_o
);
    import eep_pkg::*;

    localparam int AW = $clog2(MEM_DEPTH);
    localparam int OW = $clog2(PAGE_BYTES);
    localparam int PW = AW - OW;
    localparam int CW = $clog2(WR_CYCLES + 1);

    typedef struct packed {
        eep_st_e       st;
        logic [3:0]    bcnt;   // 0..7 bits, 8 = byte done, 9 = ack slot
        logic [7:0]    sh;
        logic          drv;
        logic          rd;
        logic [AW-1:0] ptr;
        logic          wbad;
        logic [CW-1:0] busy;
        logic [PW-1:0] wpage;
    } regs_t;

    regs_t r_q, r_d;

    logic scl_s, sda_s, start, stop, rise, fall;
    logic pb_clr, pb_wr, commit, busy;
    logic [PAGE_BYTES*8-1:0] pb_data;
    logic [PAGE_BYTES-1:0]   pb_mask;
    logic [7:0]              rdata;

    eep_bus_sense u_sense (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .start_o(start), .stop_o(stop),
        .rise_o(rise), .fall_o(fall)
    );

    eep_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr_i(pb_clr), .wr_i(pb_wr),
        .idx_i(r_q.ptr[OW-1:0]), .byte_i(r_q.sh),
        .data_o(pb_data), .mask_o(pb_mask)
    );

    eep_array #(.MEM_DEPTH(MEM_DEPTH), .PAGE_BYTES(PAGE_BYTES)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_i(commit), .page_i(r_q.wpage),
        .data_i(pb_data), .mask_i(pb_mask), .raddr_i(r_q.ptr), .rdata_o(rdata)
    );

    assign busy = (r_q.busy != '0);

    always_comb begin
        r_d    = r_q;
        pb_clr = 1'b0;
        pb_wr  = 1'b0;
        commit = 1'b0;

        if (busy) begin
            r_d.busy = r_q.busy - 1'b1;
            if (r_q.busy == CW'(1)) begin
                commit = 1'b1;
                pb_clr = 1'b1;
            end
        end

        if (!wen_i && (r_q.st == S_CTRL || r_q.st == S_ADDR || r_q.st == S_WDAT))
            r_d.wbad = 1'b1;

        if (start) begin
            r_d.st   = S_CTRL;
            r_d.bcnt = 4'd0;
            r_d.drv  = 1'b0;
            r_d.wbad = !wen_i;
        end else if (stop) begin
            if (r_q.st == S_WDAT && pb_mask != '0 && !r_q.wbad && !busy) begin
                r_d.busy  = CW'(WR_CYCLES);
                r_d.wpage = r_q.ptr[AW-1:OW];
            end
            r_d.st  = S_IDLE;
            r_d.drv = 1'b0;
        end else begin
            case (r_q.st)
                S_CTRL, S_ADDR, S_WDAT: begin
                    if (rise && r_q.bcnt < 4'd8) begin
                        r_d.sh   = {r_q.sh[6:0], sda_s};
                        r_d.bcnt = r_q.bcnt + 4'd1;
                    end else if (fall && r_q.bcnt == 4'd8) begin
                        r_d.bcnt = 4'd9;
                        r_d.drv  = 1'b1;
                        if (r_q.st == S_CTRL) begin
                            if (r_q.sh[7:1] != DEV_ID || busy) begin
                                r_d.st  = S_IDLE;
                                r_d.drv = 1'b0;
                            end else begin
                                r_d.rd = r_q.sh[0];
                            end
                        end else if (r_q.st == S_ADDR) begin
                            r_d.ptr = r_q.sh[AW-1:0];
                            pb_clr  = 1'b1;
                        end else begin
                            pb_wr   = 1'b1;
                            r_d.ptr = {r_q.ptr[AW-1:OW], r_q.ptr[OW-1:0] + 1'b1};
                        end
                    end else if (fall && r_q.bcnt == 4'd9) begin
                        r_d.bcnt = 4'd0;
                        r_d.drv  = 1'b0;
                        if (r_q.st == S_CTRL) begin
                            if (r_q.rd) begin
                                r_d.st  = S_TX;
                                r_d.sh  = rdata;
                                r_d.drv = ~rdata[7];
                                r_d.ptr = r_q.ptr + 1'b1;
                            end else begin
                                r_d.st = S_ADDR;
                            end
                        end else if (r_q.st == S_ADDR) begin
                            r_d.st = S_WDAT;
                        end
                    end
                end
                S_TX: begin
                    if (rise && r_q.bcnt < 4'd8) begin
                        r_d.bcnt = r_q.bcnt + 4'd1;
                    end else if (fall && r_q.bcnt != 4'd0 && r_q.bcnt < 4'd8) begin
                        r_d.sh  = {r_q.sh[6:0], 1'b0};
                        r_d.drv = ~r_q.sh[6];
                    end else if (fall && r_q.bcnt == 4'd8) begin
                        r_d.drv = 1'b0;
                    end else if (rise && r_q.bcnt == 4'd8) begin
                        if (!sda_s) begin
                            r_d.sh   = rdata;
                            r_d.ptr  = r_q.ptr + 1'b1;
                            r_d.bcnt = 4'd9;
                        end else begin
                            r_d.st = S_IDLE;
                        end
                    end else if (fall && r_q.bcnt == 4'd9) begin
                        r_d.bcnt = 4'd0;
                        r_d.drv  = ~r_q.sh[7];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;   // S_IDLE, pointer 0, not busy
        else        r_q <= r_d;
    end

    assign sda_pull_o = r_q.drv;

    // R6: silent for the whole internal cycle
    a_r6_silent_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.busy != '0) |-> !r_q.drv);
    // R2: a start always resynchronises to a fresh control byte
    a_r2_start_resync: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (r_q.st == S_CTRL && r_q.bcnt == 4'd0));
    // R4: page bits stay fixed during a data phase
    a_r4_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_WDAT) |=> (r_q.st != S_WDAT || $stable(r_q.ptr[AW-1:OW])));
    // R12: drive is only asserted while SCL is low
    a_r12_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.drv) |-> !scl_s);
    // R7: a blocked write never starts a cycle
    a_r7_blocked_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && r_q.wbad && r_q.busy == '0) |=> (r_q.busy == '0));
    // R11: a stop with an empty buffer never starts a cycle
    a_r11_empty_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && pb_mask == '0 && r_q.busy == '0) |=> (r_q.busy == '0));
endmodule

// File: tb/sim_i2c_page_eeprom.sv
module sim_i2c_page_eeprom;
    localparam int WR  = 600;
    localparam int Q   = 5;
    localparam int ACK = 0;
    localparam int NAK = 1;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, wen = 1'b1;
    logic pull;
    logic sda_line;
    assign sda_line = sda_m & ~pull;

    i2c_page_eeprom #(.WR_CYCLES(WR)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .wen_i(wen), .sda_pull_o(pull)
    );

    int    n_chk = 0, n_err = 0, viol = 0;
    int    exp_v[$];
    string exp_t[$];
    int    obs_v[$];
    logic  pull_prev = 1'b0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    initial forever begin
        @(negedge clk);
        while (obs_v.size() > 0) begin
            if (exp_v.size() == 0) begin
                n_chk++; n_err++;
                $display("FAIL R3 unexpected item actual=%0h expected=none", obs_v.pop_front());
            end else begin
                chk(exp_t.pop_front(), obs_v.pop_front(), exp_v.pop_front());
            end
        end
    end

    // R12: slave drive must not change while SCL is high
    always @(negedge clk) begin
        if (pull !== pull_prev && scl_m) viol++;
        pull_prev = pull;
    end

    task automatic waitq(int n = Q);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitq();
        scl_m = 1'b1; waitq();
        sda_m = 1'b0; waitq();
        scl_m = 1'b0; waitq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitq();
        scl_m = 1'b1; waitq();
        sda_m = 1'b1; waitq();
    endtask

    task automatic bit_io(input logic b, output logic s);
        sda_m = b;    waitq();
        scl_m = 1'b1; waitq();
        s = sda_line; waitq();
        scl_m = 1'b0; waitq();
    endtask

    task automatic send(input logic [7:0] v, input int eack, input string tag);
        logic s;
        exp_v.push_back(eack);
        exp_t.push_back(tag);
        for (int i = 7; i >= 0; i--) bit_io(v[i], s);
        bit_io(1'b1, s);
        obs_v.push_back(int'(s));
    endtask

    task automatic recv(input logic mack, input int ev, input string tag);
        logic s;
        logic [7:0] r = '0;
        exp_v.push_back(ev);
        exp_t.push_back(tag);
        for (int i = 0; i < 8; i++) begin
            bit_io(1'b1, s);
            r = {r[6:0], s};
        end
        bit_io(mack, s);
        obs_v.push_back(int'(r));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        waitq(10);
        rst_n = 1'b1;
        waitq(5);
        chk("R1 data line released after reset", int'(pull), 0);

        // R1: current-address read right after reset
        bus_start(); send(8'hA1, ACK, "R1 read control");
        recv(1'b1, 8'h00, "R1 array cleared at pointer 0"); bus_stop();

        // R2: foreign addresses, incl. the bit-reversed code
        bus_start(); send(8'hA2, NAK, "R2 foreign address"); bus_stop();
        bus_start(); send(8'h0A, NAK, "R2 MSB-first order"); bus_stop();

        // R3/R6: byte write then polling during the cycle
        bus_start(); send(8'hA0, ACK, "R3 write control");
        send(8'h10, ACK, "R3 word address"); send(8'hA5, ACK, "R3 data byte"); bus_stop();
        bus_start(); send(8'hA0, NAK, "R6 busy own write address"); bus_stop();
        bus_start(); send(8'hA1, NAK, "R6 busy own read address"); bus_stop();
        waitq(WR);
        bus_start(); send(8'hA0, ACK, "R6 ack after cycle"); send(8'h10, ACK, "R9 address");
        bus_start(); send(8'hA1, ACK, "R9 read control");
        recv(1'b1, 8'hA5, "R3 R9 random read of byte write"); bus_stop();

        // location 0x00 for the wrap test
        bus_start(); send(8'hA0, ACK, "R3 control"); send(8'h00, ACK, "R3 address");
        send(8'hC3, ACK, "R3 data"); bus_stop();
        waitq(WR + 50);

        // R4/R5: ten bytes into page 0x20 starting at 0x23
        bus_start(); send(8'hA0, ACK, "R4 control"); send(8'h23, ACK, "R4 address");
        for (int i = 0; i < 10; i++) send(8'(8'h50 + i), ACK, "R5 page data ack");
        bus_stop();
        waitq(WR + 50);
        bus_start(); send(8'hA0, ACK, "R9 control"); send(8'h20, ACK, "R9 address");
        bus_start(); send(8'hA1, ACK, "R9 read control");
        recv(1'b0, 8'h55, "R5 slot 0");  recv(1'b0, 8'h56, "R5 slot 1");
        recv(1'b0, 8'h57, "R5 slot 2");  recv(1'b0, 8'h58, "R5 slot 3 overwritten");
        recv(1'b0, 8'h59, "R5 slot 4 overwritten"); recv(1'b0, 8'h52, "R4 slot 5");
        recv(1'b0, 8'h53, "R4 slot 6");  recv(1'b0, 8'h54, "R4 slot 7");
        recv(1'b1, 8'h00, "R4 next page untouched"); bus_stop();

        // R8: nack ends read, pointer advanced
        bus_start(); send(8'hA0, ACK, "R8 control"); send(8'h20, ACK, "R8 address");
        bus_start(); send(8'hA1, ACK, "R8 read control");
        recv(1'b0, 8'h55, "R8 first"); recv(1'b0, 8'h56, "R8 second");
        recv(1'b1, 8'h57, "R8 third");
        waitq(2);
        chk("R8 released after master nack", int'(pull), 0);
        bus_stop();
        bus_start(); send(8'hA1, ACK, "R8 read control");
        recv(1'b1, 8'h58, "R8 pointer advanced past last read"); bus_stop();

        // R7: write-enable dropped during the data byte
        bus_start(); send(8'hA0, ACK, "R7 control"); send(8'h10, ACK, "R7 address");
        wen = 1'b0; send(8'h3C, ACK, "R7 data ack"); wen = 1'b1;
        bus_stop();
        bus_start(); send(8'hA0, ACK, "R7 blocked write starts no cycle");
        send(8'h10, ACK, "R9 address");
        bus_start(); send(8'hA1, ACK, "R9 read control");
        recv(1'b1, 8'hA5, "R7 blocked data discarded"); bus_stop();

        // R7/R10: write-enable lowered during the cycle, then wrap read
        bus_start(); send(8'hA0, ACK, "R7 control"); send(8'h7E, ACK, "R7 address");
        send(8'h11, ACK, "R7 data"); send(8'h3C, ACK, "R7 data"); bus_stop();
        wen = 1'b0; waitq(WR + 50); wen = 1'b1;
        bus_start(); send(8'hA0, ACK, "R10 control"); send(8'h7E, ACK, "R10 address");
        bus_start(); send(8'hA1, ACK, "R10 read control");
        recv(1'b0, 8'h11, "R7 committed despite low enable");
        recv(1'b0, 8'h3C, "R10 byte at 0x7F");
        recv(1'b1, 8'hC3, "R10 pointer wraps to 0x00"); bus_stop();

        // R11: stop right after the word address
        bus_start(); send(8'hA0, ACK, "R11 control"); send(8'h23, ACK, "R11 address"); bus_stop();
        bus_start(); send(8'hA1, ACK, "R11 no cycle after address-only write");
        recv(1'b1, 8'h58, "R11 R9 current address read"); bus_stop();

        waitq(10);
        chk("R12 drive changes while SCL high", viol, 0);
        chk("R3 scoreboard drained", exp_v.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule